// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Overflow and Comparison

This block is the arithmetic core of a simple integer pipeline. It adds or subtracts two 32-bit two's complement operands in a single combinational pass. It returns the 32-bit result, the carry out of the top bit, and a signed overflow flag that a surrounding core can turn into an exception. Overflow is raised only when the unit is in signed mode. In unsigned mode the same arithmetic runs with the flag held low.

The second operand can come from the register operand or from a widened 16-bit immediate:

- By default the immediate is widened by replicating its top bit. This also holds for the unsigned immediate add.
- A separate zero-fill control serves logical immediates.

The unit also produces two less-than results from the first operand and the selected second operand, one signed and one unsigned. Both are valid in every cycle, whatever the add/subtract and mode inputs are.

Top module: `asu_core`

## Requirements
- R1: With subtract=0, result equals (opA + opnd) modulo 2^32, where opnd is immWide when useImm=1 and opB otherwise.
- R2: With subtract=1, result equals opA plus the bitwise inverse of opnd plus one, modulo 2^32, which is opA - opnd.
- R3: With signedMode=1 and subtract=0, overflow is 1 exactly when opA and opnd have equal bit 31 and result bit 31 differs from it; operands of opposite sign never set it.
- R4: With signedMode=1 and subtract=1, overflow is 1 exactly when opA and opnd differ in bit 31 and result bit 31 differs from opA bit 31; operands of equal sign never set it.
- R5: With signedMode=0, overflow is 0 for every operand and operation.
- R6: carryOut is bit 32 of opA + opnd (add) or of opA + ~opnd + 1 (subtract), independent of signedMode and of overflow.
- R7: With zeroExtImm=0, immWide[31:16] all equal imm[15] and immWide[15:0] equals imm, in both signed and unsigned mode.
- R8: With zeroExtImm=1, immWide[31:16] is 0 and immWide[15:0] equals imm.
- R9: ltSigned is 1 exactly when opA < opnd as signed 32-bit values, and ltUnsigned is 1 exactly when opA < opnd as unsigned values, regardless of subtract and signedMode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand |
| opB | input | 32 | Register second operand |
| imm | input | 16 | Immediate field |
| useImm | input | 1 | 1 selects widened immediate as second operand |
| zeroExtImm | input | 1 | 1 widens immediate with zeros, 0 with its top bit |
| subtract | input | 1 | 0 add, 1 subtract |
| signedMode | input | 1 | 1 enables the overflow flag |
| result | output | 32 | Sum or difference |
| carryOut | output | 1 | Carry out of bit 31 |
| overflow | output | 1 | Signed overflow flag |
| immWide | output | 32 | Widened immediate |
| ltSigned | output | 1 | opA less than operand, signed |
| ltUnsigned | output | 1 | opA less than operand, unsigned |

## Verification
The checker evaluates the port relations that hold for any input on every evaluation. It checks that the flag stays low in unsigned mode and for sign patterns that cannot overflow. It checks the fill of the widened immediate in both extension modes. It also checks both comparison outputs against an arithmetic comparison. The exact result and carry values, and the cases where overflow must be raised, depend on particular operand values: the 0x7FFFFFFF + 1 and 0x80000000 - 1 edges, wrap-around at all ones, and an immediate used in unsigned mode. Only the bench scenarios demonstrate these.

// File: rtl/asu_pkg.sv
package asu_pkg;
  typedef struct packed {
    logic invertB;   // complement second operand
    logic carryIn;   // inject +1 at bit 0
    logic selImm;    // take immediate as second operand
    logic zeroFill;  // widen immediate with zeros
    logic flagEn;    // allow overflow flag
  } asuCtrl_t;
endpackage

// File: rtl/asu_ctrl.sv
module asu_ctrl
  import asu_pkg::*;
(
  input  logic     useImm,
  input  logic     zeroExtImm,
  input  logic     subtract,
  input  logic     signedMode,
  output asuCtrl_t ctrl
);
  always_comb begin
    ctrl.invertB  = subtract;
    ctrl.carryIn  = subtract;
    ctrl.selImm   = useImm;
    ctrl.zeroFill = zeroExtImm;
    ctrl.flagEn   = signedMode;
  end
endmodule

// File: rtl/asu_datapath.sv
module asu_datapath
  import asu_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int IMM_WIDTH = 16
) (
  input  logic [WIDTH-1:0]     opA,
  input  logic [WIDTH-1:0]     opB,
  input  logic [IMM_WIDTH-1:0] imm,
  input  asuCtrl_t             ctrl,
  output logic [WIDTH-1:0]     result,
  output logic                 carryOut,
  output logic                 overflow,
  output logic [WIDTH-1:0]     immWide,
  output logic                 ltSigned,
  output logic                 ltUnsigned
);
  localparam int EXT = WIDTH - IMM_WIDTH;
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] operand;
  logic [WIDTH-1:0] addend;
  logic [WIDTH:0]   total;
  logic [WIDTH:0]   diff;
  logic             cmpOvf;

  generate
    if (EXT > 0) begin : g_widen
      always_comb begin
        if (ctrl.zeroFill) immWide = {{EXT{1'b0}}, imm};
        else               immWide = {{EXT{imm[IMM_WIDTH-1]}}, imm};
      end
    end else begin : g_same
      always_comb immWide = imm[WIDTH-1:0];
    end
  endgenerate

  always_comb begin
    operand  = ctrl.selImm ? immWide : opB;
    addend   = ctrl.invertB ? ~operand : operand;
    total    = {1'b0, opA} + {1'b0, addend} + {{WIDTH{1'b0}}, ctrl.carryIn};
    result   = total[MSB:0];
    carryOut = total[WIDTH];
    overflow = ctrl.flagEn & (opA[MSB] == addend[MSB]) & (total[MSB] != opA[MSB]);
  end

  // dedicated comparison subtractor, independent of the operation select
  always_comb begin
    diff       = {1'b0, opA} + {1'b0, ~operand} + {{WIDTH{1'b0}}, 1'b1};
    cmpOvf     = (opA[MSB] != operand[MSB]) & (diff[MSB] != opA[MSB]);
    ltSigned   = diff[MSB] ^ cmpOvf;
    ltUnsigned = ~diff[WIDTH];
  end
endmodule

// File: rtl/asu_core.sv
module asu_core
  import asu_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int IMM_WIDTH = 16
) (
  input  logic [WIDTH-1:0]     opA,
  input  logic [WIDTH-1:0]     opB,
  input  logic [IMM_WIDTH-1:0] imm,
  input  logic                 useImm,
  input  logic                 zeroExtImm,
  input  logic                 subtract,
  input  logic                 signedMode,
  output logic [WIDTH-1:0]     result,
  output logic                 carryOut,
  output logic                 overflow,
  output logic [WIDTH-1:0]     immWide,
  output logic                 ltSigned,
  output logic                 ltUnsigned
);
  asuCtrl_t ctrl;

  asu_ctrl u_ctrl (
    .useImm(useImm), .zeroExtImm(zeroExtImm), .subtract(subtract),
    .signedMode(signedMode), .ctrl(ctrl)
  );

  asu_datapath #(.WIDTH(WIDTH), .IMM_WIDTH(IMM_WIDTH)) u_dp (
    .opA(opA), .opB(opB), .imm(imm), .ctrl(ctrl),
    .result(result), .carryOut(carryOut), .overflow(overflow),
    .immWide(immWide), .ltSigned(ltSigned), .ltUnsigned(ltUnsigned)
  );
endmodule

// File: rtl/asu_checker.sv
module asu_checker #(
  parameter int WIDTH     = 32,
  parameter int IMM_WIDTH = 16
) (
  input logic [WIDTH-1:0]     opA,
  input logic [WIDTH-1:0]     opB,
  input logic [IMM_WIDTH-1:0] imm,
  input logic                 useImm,
  input logic                 zeroExtImm,
  input logic                 subtract,
  input logic                 signedMode,
  input logic [WIDTH-1:0]     result,
  input logic                 carryOut,
  input logic                 overflow,
  input logic [WIDTH-1:0]     immWide,
  input logic                 ltSigned,
  input logic                 ltUnsigned
);
  localparam int MSB = WIDTH - 1;
  localparam int EXT = WIDTH - IMM_WIDTH;
  logic [WIDTH-1:0] opnd;
  assign opnd = useImm ? immWide : opB;

  always_comb begin
    // R5: unsigned mode keeps the flag low
    p_no_overflow_r5: assert (signedMode || !overflow)
      else $error("R5 overflow raised in unsigned mode");
    // R3: opposite-sign add cannot overflow
    p_add_mixed_r3: assert (subtract || opA[MSB] == opnd[MSB] || !overflow)
      else $error("R3 overflow on mixed-sign add");
    // R4: same-sign subtract cannot overflow
    p_sub_same_r4: assert (!subtract || opA[MSB] != opnd[MSB] || !overflow)
      else $error("R4 overflow on same-sign subtract");
    // R7: sign fill of the immediate
    p_sign_fill_r7: assert (zeroExtImm || immWide == {{EXT{imm[IMM_WIDTH-1]}}, imm})
      else $error("R7 sign fill wrong");
    // R8: zero fill of the immediate
    p_zero_fill_r8: assert (!zeroExtImm || immWide == {{EXT{1'b0}}, imm})
      else $error("R8 zero fill wrong");
    // R9: comparisons match arithmetic ordering
    p_lt_unsigned_r9: assert (ltUnsigned == (opA < opnd))
      else $error("R9 unsigned compare wrong");
    p_lt_signed_r9: assert (ltSigned == ($signed(opA) < $signed(opnd)))
      else $error("R9 signed compare wrong");
  end
endmodule

bind asu_core asu_checker #(.WIDTH(WIDTH), .IMM_WIDTH(IMM_WIDTH)) u_chk (.*);

// File: tb/sim_asu_core.sv
`timescale 1ns/1ps
module sim_asu_core;
  logic        clk = 1'b0;
  logic [31:0] opA, opB, result, immWide;
  logic [15:0] imm;
  logic        useImm, zeroExtImm, subtract, signedMode;
  logic        carryOut, overflow, ltSigned, ltUnsigned;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  asu_core u0 (
    .opA(opA), .opB(opB), .imm(imm), .useImm(useImm), .zeroExtImm(zeroExtImm),
    .subtract(subtract), .signedMode(signedMode), .result(result),
    .carryOut(carryOut), .overflow(overflow), .immWide(immWide),
    .ltSigned(ltSigned), .ltUnsigned(ltUnsigned)
  );

  // stimulus: {opA, opB, subtract, signedMode}
  localparam logic [65:0] VEC [12] = '{
    {32'h0000_0005, 32'h0000_0003, 1'b0, 1'b1},
    {32'h0000_0005, 32'h0000_0007, 1'b1, 1'b1},
    {32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b1},
    {32'h8000_0000, 32'h0000_0001, 1'b1, 1'b1},
    {32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1},
    {32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b1},
    {32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1},
    {32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 1'b0},
    {32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b0},
    {32'h1234_5678, 32'hEDCB_A988, 1'b0, 1'b1},
    {32'hC000_0000, 32'h4000_0000, 1'b1, 1'b1},
    {32'h0000_0000, 32'h8000_0000, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [15:0] i,
                       input logic ui, input logic ze, input logic sb, input logic sm);
    @(negedge clk);
    opA = a; opB = b; imm = i; useImm = ui; zeroExtImm = ze; subtract = sb; signedMode = sm;
    #1;
  endtask

  // independent reference built from integer arithmetic
  task automatic reference(input logic [31:0] a, input logic [31:0] b, input logic sb,
                           input logic sm);
    longint sa, sbv, r;
    logic [32:0] wide;
    sa = longint'($signed(a));
    sbv = longint'($signed(b));
    r = sb ? sa - sbv : sa + sbv;
    wide = sb ? ({1'b0, a} + {1'b0, ~b} + 33'd1) : ({1'b0, a} + {1'b0, b});
    check(sb ? "R2 result" : "R1 result", result, wide[31:0]);
    check("R6 carry", {31'd0, carryOut}, {31'd0, wide[32]});
    check(sm ? (sb ? "R4 overflow" : "R3 overflow") : "R5 overflow", {31'd0, overflow},
          {31'd0, sm && (r > 64'sd2147483647 || r < -64'sd2147483648)});
    check("R9 signed lt", {31'd0, ltSigned}, {31'd0, sa < sbv});
    check("R9 unsigned lt", {31'd0, ltUnsigned}, {31'd0, a < b});
  endtask

  initial begin
    #50000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // idle state after start-up: all-zero inputs give zero outputs
    apply(0, 0, 0, 0, 0, 0, 0);
    check("R1 idle result", result, 32'h0);
    check("R5 idle overflow", {31'd0, overflow}, 32'h0);

    for (int k = 0; k < 12; k++) begin
      apply(VEC[k][65:34], VEC[k][33:2], 16'h0, 1'b0, 1'b0, VEC[k][1], VEC[k][0]);
      reference(VEC[k][65:34], VEC[k][33:2], VEC[k][1], VEC[k][0]);
    end

    // directed edges
    apply(32'h7FFF_FFFF, 32'h1, 0, 0, 0, 0, 1);
    check("R3 max+1 result", result, 32'h8000_0000);
    check("R3 max+1 overflow", {31'd0, overflow}, 32'h1);
    check("R6 max+1 carry", {31'd0, carryOut}, 32'h0);
    apply(32'h8000_0000, 32'h1, 0, 0, 0, 1, 1);
    check("R4 min-1 result", result, 32'h7FFF_FFFF);
    check("R4 min-1 overflow", {31'd0, overflow}, 32'h1);
    check("R6 min-1 carry", {31'd0, carryOut}, 32'h1);
    apply(32'h7FFF_FFFF, 32'h1, 0, 0, 0, 0, 0);
    check("R5 unsigned max+1 overflow", {31'd0, overflow}, 32'h0);
    apply(32'hFFFF_FFFF, 32'h1, 0, 0, 0, 0, 0);
    check("R6 wrap carry", {31'd0, carryOut}, 32'h1);
    check("R1 wrap result", result, 32'h0);

    // immediates: unsigned-mode add still sign-widens
    apply(32'h0000_0010, 32'hDEAD_BEEF, 16'hFFFF, 1, 0, 0, 0);
    check("R7 immWide neg", immWide, 32'hFFFF_FFFF);
    check("R7 imm add result", result, 32'h0000_000F);
    check("R6 imm add carry", {31'd0, carryOut}, 32'h1);
    apply(32'h0, 32'h0, 16'h8000, 1, 0, 0, 1);
    check("R7 immWide signed", immWide, 32'hFFFF_8000);
    check("R9 imm signed lt", {31'd0, ltSigned}, 32'h0);
    check("R9 imm unsigned lt", {31'd0, ltUnsigned}, 32'h1);
    apply(32'h0, 32'h0, 16'h1234, 1, 0, 0, 1);
    check("R7 immWide pos", immWide, 32'h0000_1234);
    apply(32'h0000_0001, 32'h0, 16'hF00F, 1, 1, 0, 0);
    check("R8 immWide zero fill", immWide, 32'h0000_F00F);
    check("R8 zero fill add", result, 32'h0000_F010);
    apply(32'h0000_0001, 32'h0, 16'hF00F, 1, 1, 1, 1);
    check("R9 zero fill signed lt", {31'd0, ltSigned}, 32'h1);
    check("R2 zero fill sub", result, 32'hFFFF_0FF2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule